// File: doc/BRIEF.md
# Pipelined Bitonic Key Sorter

This block orders a set of N keys (N a power of two) into increasing order every clock cycle. It is built from compare-exchange cells arranged as a sort-by-merging network. Merge step j combines sorted runs of length 2^(j-1) into runs of length 2^j. Within every step except the last, neighbouring mergers alternate between producing ascending and descending runs. Each pair of runs that meets in the next step therefore forms a bitonic sequence. The final step builds one ascending run.

Every cell is one of two kinds. An ascending cell (down-sorter) puts the smaller key on its lower-numbered lane. A descending cell (up-sorter) puts the larger key there. Every cell stage is followed by a register, so every key crosses the same number of cells and the same number of flops. A new set of keys can enter on every cycle. Each key can carry an optional tag that moves with it through every exchange. A valid strobe travels alongside the data. Output keys are only meaningful in cycles when that strobe is high.

Top module: `bitonic_sorter`

## Requirements
- R1: When `out_valid` is high, the output lanes are in non-decreasing order. Lane 0 is bits [KEY_W-1:0] of `keys_out` and holds the smallest key; lane N-1 holds the largest.
- R2: The keys presented together are a permutation of one accepted input set. Duplicate keys are kept, not dropped or merged.
- R3: Each output tag is the tag that entered alongside that same key. Lane i of `tags_in` belongs to lane i of `keys_in`.
- R4: `out_valid` rises exactly LOG2N*(LOG2N+1)/2 clock cycles after the edge that captures a set with `in_valid` high. This is 10 cycles for N=16.
- R5: Sets presented on consecutive cycles are each delivered on consecutive cycles, in the order they entered, with none lost.
- R6: A cell never exchanges equal keys. When all N keys of a set are equal, the output tags therefore appear in their input lane order.
- R7: While `rst_n` is low and directly after its release, `out_valid` is low.
- R8: A cycle with `in_valid` low produces no output cycle with `out_valid` high. The number of valid output cycles equals the number of accepted input cycles.
- R9: The smallest and largest representable keys (all zeros, all ones) sort correctly, including sets made only of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input set is present this cycle |
| keys_in | input | N*KEY_W | N keys; lane i at bits [i*KEY_W +: KEY_W] |
| tags_in | input | N*TAG_W | Tag for each key lane, same lane layout |
| out_valid | output | 1 | Sorted set is present this cycle |
| keys_out | output | N*KEY_W | Keys in increasing order, lane 0 smallest |
| tags_out | output | N*TAG_W | Tags that travelled with the output keys |

## Verification
Consider a cell with the wrong direction, a wrong partner span, or a swapped tag path. It shows up as an unordered or wrong output set, or a mismatched tag, exactly the stage count of cycles after the bad set enters. A broken valid chain shows as an output strobe at the wrong cycle or a missing result. The scoreboard catches this in the very next comparison. Inputs with all keys equal expose a cell that swaps on ties, because the tags come out reordered.

// File: rtl/sort_net_pkg.sv
package sort_net_pkg;

  // Number of registered cell stages for 2^lg keys.
  function automatic int num_stages(int lg);
    return lg * (lg + 1) / 2;
  endfunction

  // Merge step (1..lg) that stage s belongs to.
  function automatic int step_of(int s, int lg);
    int acc;
    acc = 0;
    for (int j = 1; j <= lg; j++) begin
      if (s < acc + j) return j;
      acc += j;
    end
    return lg;
  endfunction

  // Lane distance between the two inputs of a cell at stage s.
  function automatic int span_of(int s, int lg);
    int acc;
    acc = 0;
    for (int j = 1; j <= lg; j++) begin
      if (s < acc + j) return 1 << (j - 1 - (s - acc));
      acc += j;
    end
    return 1;
  endfunction

  // A cell whose lower lane is 'lane' in merge step 'step' builds a
  // descending run when bit 'step' of the lane is set; the last step is
  // always ascending.
  function automatic bit lane_descends(int lane, int step, int lg);
    return (step < lg) && (((lane >> step) & 1) == 1);
  endfunction

endpackage

// File: rtl/sort_cell.sv
module sort_cell #(
  parameter int  KEY_W   = 8,
  parameter int  TAG_W   = 4,
  parameter bit  DESCEND = 1'b0
) (
  input  logic [KEY_W-1:0] a_key,
  input  logic [TAG_W-1:0] a_tag,
  input  logic [KEY_W-1:0] b_key,
  input  logic [TAG_W-1:0] b_tag,
  output logic [KEY_W-1:0] lo_key,
  output logic [TAG_W-1:0] lo_tag,
  output logic [KEY_W-1:0] hi_key,
  output logic [TAG_W-1:0] hi_tag,
  output logic             swap
);
  // Strict comparison: equal keys stay where they are.
  always_comb begin
    swap   = DESCEND ? (a_key < b_key) : (a_key > b_key);
    lo_key = swap ? b_key : a_key;
    lo_tag = swap ? b_tag : a_tag;
    hi_key = swap ? a_key : b_key;
    hi_tag = swap ? a_tag : b_tag;
  end
endmodule

// File: rtl/sort_stage.sv
module sort_stage
  import sort_net_pkg::*;
#(
  parameter int LOG2N = 4,
  parameter int KEY_W = 8,
  parameter int TAG_W = 4,
  parameter int STAGE = 0,
  localparam int N    = 1 << LOG2N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             v_in,
  input  logic [KEY_W-1:0] k_in [N],
  input  logic [TAG_W-1:0] t_in [N],
  output logic             v_out,
  output logic [KEY_W-1:0] k_out [N],
  output logic [TAG_W-1:0] t_out [N]
);
  localparam int STEP = step_of(STAGE, LOG2N);
  localparam int SPAN = span_of(STAGE, LOG2N);
  localparam int SKW  = KEY_W + LOG2N;
  localparam int STW  = TAG_W + LOG2N;

  logic [KEY_W-1:0] k_nx [N];
  logic [TAG_W-1:0] t_nx [N];

  for (genvar i = 0; i < N; i++) begin : g_lane
    if ((i & SPAN) == 0) begin : g_cell
      localparam bit DESC = lane_descends(i, STEP, LOG2N);
      logic swap_w;

      sort_cell #(.KEY_W(KEY_W), .TAG_W(TAG_W), .DESCEND(DESC)) u_cell (
        .a_key (k_in[i]),        .a_tag (t_in[i]),
        .b_key (k_in[i+SPAN]),   .b_tag (t_in[i+SPAN]),
        .lo_key(k_nx[i]),        .lo_tag(t_nx[i]),
        .hi_key(k_nx[i+SPAN]),   .hi_tag(t_nx[i+SPAN]),
        .swap  (swap_w)
      );

      // R4 / R1: each registered pair follows its cell's direction
      p_pair_dir_r1: assert property (@(posedge clk) disable iff (!rst_n)
        v_out |-> (DESC ? (k_out[i] >= k_out[i+SPAN])
                        : (k_out[i] <= k_out[i+SPAN])));

      // R6: equal keys are never exchanged
      p_tie_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (v_in && (k_in[i] == k_in[i+SPAN])) |-> !swap_w);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_out <= 1'b0;
      k_out <= '{default: '0};
      t_out <= '{default: '0};
    end else begin
      v_out <= v_in;
      if (v_in) begin
        k_out <= k_nx;
        t_out <= t_nx;
      end
    end
  end

  // Named sums for conservation checks.
  logic [SKW-1:0] ksum_in, ksum_out;
  logic [STW-1:0] tsum_in, tsum_out;
  always_comb begin
    ksum_in = '0; ksum_out = '0; tsum_in = '0; tsum_out = '0;
    for (int i = 0; i < N; i++) begin
      ksum_in  += SKW'(k_in[i]);
      ksum_out += SKW'(k_out[i]);
      tsum_in  += STW'(t_in[i]);
      tsum_out += STW'(t_out[i]);
    end
  end

  p_key_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
    v_out |-> (ksum_out == $past(ksum_in)));

  p_tag_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
    v_out |-> (tsum_out == $past(tsum_in)));

endmodule

// File: rtl/bitonic_sorter.sv
module bitonic_sorter
  import sort_net_pkg::*;
#(
  parameter int LOG2N = 4,
  parameter int KEY_W = 8,
  parameter int TAG_W = 4,
  localparam int N    = 1 << LOG2N
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [N*KEY_W-1:0] keys_in,
  input  logic [N*TAG_W-1:0] tags_in,
  output logic               out_valid,
  output logic [N*KEY_W-1:0] keys_out,
  output logic [N*TAG_W-1:0] tags_out
);
  localparam int NSTAGE = num_stages(LOG2N);

  logic [KEY_W-1:0] k_src [N];
  logic [TAG_W-1:0] t_src [N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      k_src[i] = keys_in[i*KEY_W +: KEY_W];
      t_src[i] = tags_in[i*TAG_W +: TAG_W];
    end
  end

  for (genvar s = 0; s < NSTAGE; s++) begin : g_st
    logic             v_q;
    logic [KEY_W-1:0] k_q [N];
    logic [TAG_W-1:0] t_q [N];
    if (s == 0) begin : g_first
      sort_stage #(.LOG2N(LOG2N), .KEY_W(KEY_W), .TAG_W(TAG_W), .STAGE(s)) u_stage (
        .clk(clk), .rst_n(rst_n),
        .v_in(in_valid), .k_in(k_src), .t_in(t_src),
        .v_out(v_q), .k_out(k_q), .t_out(t_q)
      );
    end else begin : g_next
      sort_stage #(.LOG2N(LOG2N), .KEY_W(KEY_W), .TAG_W(TAG_W), .STAGE(s)) u_stage (
        .clk(clk), .rst_n(rst_n),
        .v_in(g_st[s-1].v_q), .k_in(g_st[s-1].k_q), .t_in(g_st[s-1].t_q),
        .v_out(v_q), .k_out(k_q), .t_out(t_q)
      );
    end
  end

  always_comb begin
    out_valid = g_st[NSTAGE-1].v_q;
    for (int i = 0; i < N; i++) begin
      keys_out[i*KEY_W +: KEY_W] = g_st[NSTAGE-1].k_q[i];
      tags_out[i*TAG_W +: TAG_W] = g_st[NSTAGE-1].t_q[i];
    end
  end

  // R1: neighbouring output lanes are ordered whenever the set is valid
  for (genvar i = 0; i < N - 1; i++) begin : g_ord
    p_sorted_out_r1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (keys_out[i*KEY_W +: KEY_W] <= keys_out[(i+1)*KEY_W +: KEY_W]));
  end

endmodule

// File: tb/test_bitonic_sorter.sv
`timescale 1ns/1ps
module test_bitonic_sorter;
  localparam int LOG2N  = 4;
  localparam int KEY_W  = 8;
  localparam int TAG_W  = 4;
  localparam int N      = 1 << LOG2N;
  localparam int NSTAGE = LOG2N * (LOG2N + 1) / 2;
  localparam int KV     = N * KEY_W;
  localparam int TV     = N * TAG_W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [KV-1:0] keys_in = '0;
  logic [TV-1:0] tags_in = '0;
  logic          out_valid;
  logic [KV-1:0] keys_out;
  logic [TV-1:0] tags_out;

  bitonic_sorter #(.LOG2N(LOG2N), .KEY_W(KEY_W), .TAG_W(TAG_W)) i_bitonic_sorter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .keys_in(keys_in), .tags_in(tags_in),
    .out_valid(out_valid), .keys_out(keys_out), .tags_out(tags_out)
  );

  always #10 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  int n_sent = 0;
  int n_got  = 0;

  logic [KV-1:0] q_k [$];
  logic [TV-1:0] q_t [$];
  int            q_c [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, string what,
                       logic [KV-1:0] act, logic [KV-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [TAG_W-1:0] tag_of(logic [KEY_W-1:0] k);
    return k[7:4] ^ k[3:0] ^ 4'h9;
  endfunction

  // Drive one set; lane_tags gives each key its lane number as tag (used
  // only for all-equal sets), otherwise the tag is a function of the key.
  task automatic send(input logic [KEY_W-1:0] kv [N], input bit lane_tags);
    logic [KEY_W-1:0] srt [N];
    logic [KV-1:0]    ek;
    logic [TV-1:0]    et, ti;
    logic [KV-1:0]    ki;
    srt = kv;
    for (int a = 0; a < N - 1; a++)
      for (int b = 0; b < N - 1 - a; b++)
        if (srt[b] > srt[b+1]) begin
          logic [KEY_W-1:0] tmp;
          tmp = srt[b]; srt[b] = srt[b+1]; srt[b+1] = tmp;
        end
    for (int i = 0; i < N; i++) begin
      ki[i*KEY_W +: KEY_W] = kv[i];
      ti[i*TAG_W +: TAG_W] = lane_tags ? TAG_W'(i) : tag_of(kv[i]);
      ek[i*KEY_W +: KEY_W] = srt[i];
      et[i*TAG_W +: TAG_W] = lane_tags ? TAG_W'(i) : tag_of(srt[i]);
    end
    @(negedge clk);
    keys_in  = ki;
    tags_in  = ti;
    in_valid = 1'b1;
    q_k.push_back(ek);
    q_t.push_back(et);
    q_c.push_back(cyc);
    n_sent++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      keys_in  = {KV{1'b1}};
    end
  endtask

  // Monitor: pops the scoreboard whenever a sorted set appears.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      n_got++;
      if (q_k.size() == 0) begin
        check(1'b0, "R8", "unexpected output set", keys_out, '0);
      end else begin
        logic [KV-1:0] ek;
        logic [TV-1:0] et;
        int            c0;
        ek = q_k.pop_front();
        et = q_t.pop_front();
        c0 = q_c.pop_front();
        check(keys_out == ek, "R1/R2", "sorted keys", keys_out, ek);
        check(tags_out == et, "R3/R6", "tags", KV'(tags_out), KV'(et));
        check((cyc - c0) == NSTAGE, "R4", "latency",
              KV'(cyc - c0), KV'(NSTAGE));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [KEY_W-1:0] kv [N];
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R7", "out_valid in reset", KV'(out_valid), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R7", "out_valid after reset", KV'(out_valid), '0);

    for (int i = 0; i < N; i++) kv[i] = KEY_W'(i * 3);           // ascending
    send(kv, 1'b0);
    for (int i = 0; i < N; i++) kv[i] = KEY_W'(250 - i * 7);     // descending
    send(kv, 1'b0);
    for (int i = 0; i < N; i++) kv[i] = 8'h5A;                   // R6 ties
    send(kv, 1'b1);
    for (int i = 0; i < N; i++) kv[i] = 8'hFF;                   // R9 max
    send(kv, 1'b1);
    for (int i = 0; i < N; i++) kv[i] = 8'h00;                   // R9 min
    send(kv, 1'b1);
    for (int i = 0; i < N; i++) kv[i] = (i % 2) ? 8'hFF : 8'h00; // R9 mixed
    send(kv, 1'b0);
    idle(4);

    // R5: back-to-back burst with many duplicates
    for (int n = 0; n < 40; n++) begin
      for (int i = 0; i < N; i++)
        kv[i] = (n % 2) ? KEY_W'($urandom % 6) : KEY_W'($urandom);
      send(kv, 1'b0);
    end

    // R8: sets separated by random idle gaps
    for (int n = 0; n < 60; n++) begin
      for (int i = 0; i < N; i++) kv[i] = KEY_W'($urandom);
      send(kv, 1'b0);
      idle($urandom % 3);
    end

    idle(NSTAGE + 5);
    check(q_k.size() == 0, "R5", "sets left undelivered", KV'(q_k.size()), '0);
    check(n_got == n_sent, "R8", "output set count", KV'(n_got), KV'(n_sent));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule